// File: doc/BRIEF.md
# UART Baud Clock Source Selector

This block produces the timing strobes for a serial port: a single-cycle sample tick at sixteen times the bit rate, and a single-cycle bit tick on every sixteenth sample tick. The transmitter and receiver shifters consume both strobes. The shifters and the timer that supplies overflow pulses sit outside this block.

The frame mode picks where the timing comes from. In the two variable-rate modes, a select input chooses one of two sources. The first is a dedicated 16-bit divisor counter. The second is an overflow strobe from an external timer. Unless the rate-doubling input is set, the timer strobe is halved first. In the fixed-rate 9-bit mode, the rate comes from the CPU clock. With doubling set, the bit rate is CPU/16. With doubling clear, it is CPU/32. In the shift mode, the block issues no ticks.

Everything runs on one oscillator clock `clk_i`. CPU clock cycles are marked by the enable `cpu_en_i`. The divisor is written as two bytes. A low-byte write is only staged. It reaches the counter together with the next high-byte write, so the counter never sees a half-updated value.

Top module: `uart_baud_clk`

## Requirements
- R1: A low-byte write (`div_lo_we_i`) only stages the byte. A high-byte write (`div_hi_we_i`) commits {high, staged low} as the active divisor. If both bytes are written in the same cycle, the new low byte is used. The active divisor changes at no other time.
- R2: In a variable-rate mode (`mode_i` 2'b01 or 2'b11) with `src_sel_i`=1 and active divisor N>0, `samp_tick_o` pulses for one cycle every N clock cycles. `dbl_i` has no effect on this path.
- R3: With `src_sel_i`=1 in a variable-rate mode and an active divisor of zero, no sample or bit ticks are produced.
- R4: With `src_sel_i`=0 in a variable-rate mode, sample ticks come only from `tmr_ovf_i`. The divisor counter is ignored.
- R5: On the timer path, `dbl_i`=1 gives one sample tick per overflow pulse. `dbl_i`=0 gives one sample tick per two overflow pulses.
- R6: In the fixed-rate mode (`mode_i`=2'b10), a sample tick is produced on every `cpu_en_i` cycle when `dbl_i`=1, and on every second `cpu_en_i` cycle when `dbl_i`=0. This gives bit rates of CPU/16 and CPU/32. `src_sel_i`, the divisor and `tmr_ovf_i` are ignored in this mode.
- R7: `bit_tick_o` is a one-cycle pulse that always coincides with a `samp_tick_o` pulse. Exactly 16 sample ticks pass per bit tick.
- R8: In the shift mode (`mode_i`=2'b00), neither tick is produced.
- R9: While `rst_ni` is low, both outputs are low and the active divisor is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_lo_i | input | 8 | Divisor low byte |
| div_lo_we_i | input | 1 | Low byte write strobe (stages only) |
| div_hi_i | input | 8 | Divisor high byte |
| div_hi_we_i | input | 1 | High byte write strobe (commits divisor) |
| src_sel_i | input | 1 | 0: timer overflow, 1: divisor counter |
| dbl_i | input | 1 | Rate-doubling control |
| mode_i | input | 2 | 00 shift, 01 variable 8-bit, 10 fixed 9-bit, 11 variable 9-bit |
| tmr_ovf_i | input | 1 | External timer overflow pulse |
| cpu_en_i | input | 1 | One pulse per CPU clock cycle |
| samp_tick_o | output | 1 | 16x oversampling tick |
| bit_tick_o | output | 1 | Bit-rate tick |

## Verification
The sample tick and the bit tick fire in the same cycle on every sixteenth sample. That coincidence is provoked at the fastest rates: a divisor of 1 or 2, and the fixed-rate mode with a CPU enable on every cycle. In those settings the sixteenth tick lands back to back with its neighbours. The bench counts the sample ticks between consecutive bit ticks and flags any bit tick seen without a sample tick. A bound checker separately tracks the count of sample ticks since the last bit tick, so a bit tick that is off by one position is caught.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_VAR8  = 2'b01,
    MODE_FIX9  = 2'b10,
    MODE_VAR9  = 2'b11
  } frame_mode_e;
endpackage

// File: rtl/uart_baud_div.sv
module uart_baud_div #(
  parameter int BYTE_W = 8,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic              lo_we_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              hi_we_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              tick_o
);
  logic [BYTE_W-1:0] lo_stage_q;
  logic [BYTE_W-1:0] lo_eff;
  logic [DIV_W-1:0]  div_q, cnt_q, div_new;

  assign lo_eff  = lo_we_i ? lo_i : lo_stage_q;
  assign div_new = {hi_i, lo_eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_stage_q <= '0;
      div_q      <= '0;
    end else begin
      if (lo_we_i) lo_stage_q <= lo_i;
      if (hi_we_i) div_q <= div_new;   // commit only on high byte
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hi_we_i) begin
      cnt_q <= (div_new == '0) ? '0 : div_new - DIV_W'(1);
    end else if (div_q == '0) begin
      cnt_q <= '0;
    end else if (cnt_q == '0) begin
      cnt_q <= div_q - DIV_W'(1);
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign div_o  = div_q;
  assign tick_o = (div_q != '0) && (cnt_q == '0);
endmodule

// File: rtl/uart_baud_halve.sv
module uart_baud_halve (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic bypass_i,
  output logic pulse_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= 1'b0;
    else if (pulse_i) phase_q <= ~phase_q;
  end

  assign pulse_o = pulse_i && (bypass_i || phase_q);
endmodule

// File: rtl/uart_baud_ovs.sv
module uart_baud_ovs #(
  parameter int OVS = 16,
  localparam int CNT_W = $clog2(OVS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pre_i,
  output logic samp_o,
  output logic bit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == CNT_W'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      samp_o <= 1'b0;
      bit_o  <= 1'b0;
    end else begin
      samp_o <= pre_i;
      bit_o  <= pre_i && last;
      if (pre_i) cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/uart_baud_clk.sv
module uart_baud_clk
  import uart_baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OVS    = 16,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] div_lo_i,
  input  logic              div_lo_we_i,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic              div_hi_we_i,
  input  logic              src_sel_i,
  input  logic              dbl_i,
  input  logic [1:0]        mode_i,
  input  logic              tmr_ovf_i,
  input  logic              cpu_en_i,
  output logic              samp_tick_o,
  output logic              bit_tick_o
);
  logic [DIV_W-1:0] div_act;
  logic             gen_tick, tmr_tick, cpu_tick, pre_tick;
  frame_mode_e      mode;

  assign mode = frame_mode_e'(mode_i);

  uart_baud_div #(.BYTE_W(BYTE_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_i    (div_lo_i),
    .lo_we_i (div_lo_we_i),
    .hi_i    (div_hi_i),
    .hi_we_i (div_hi_we_i),
    .div_o   (div_act),
    .tick_o  (gen_tick)
  );

  // timer path: halved unless doubling
  uart_baud_halve u_tmr_half (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (tmr_ovf_i),
    .bypass_i (dbl_i),
    .pulse_o  (tmr_tick)
  );

  // fixed path: CPU/1 or CPU/2 sample rate -> CPU/16 or CPU/32 bit rate
  uart_baud_halve u_cpu_half (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (cpu_en_i),
    .bypass_i (dbl_i),
    .pulse_o  (cpu_tick)
  );

  always_comb begin
    unique case (mode)
      MODE_VAR8, MODE_VAR9: pre_tick = src_sel_i ? gen_tick : tmr_tick;
      MODE_FIX9:            pre_tick = cpu_tick;
      default:              pre_tick = 1'b0;
    endcase
  end

  uart_baud_ovs #(.OVS(OVS)) u_ovs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pre_i  (pre_tick),
    .samp_o (samp_tick_o),
    .bit_o  (bit_tick_o)
  );
endmodule

// File: rtl/uart_baud_chk.sv
module uart_baud_chk #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16,
  localparam int SC_W = $clog2(OVS) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             src_sel_i,
  input logic             tmr_ovf_i,
  input logic             div_hi_we_i,
  input logic [DIV_W-1:0] div_act_i,
  input logic             samp_tick_o,
  input logic             bit_tick_o
);
  logic var_mode;
  logic [SC_W-1:0] scnt_q;

  assign var_mode = (mode_i == 2'b01) || (mode_i == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          scnt_q <= '0;
    else if (bit_tick_o)  scnt_q <= '0;
    else if (samp_tick_o) scnt_q <= scnt_q + SC_W'(1);
  end

  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_hi_we_i |=> $stable(div_act_i)); // R1
  AST_ZERO_DIV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (var_mode && src_sel_i && div_act_i == '0) |=> !samp_tick_o); // R3
  AST_TMR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (var_mode && !src_sel_i && !tmr_ovf_i) |=> !samp_tick_o); // R4
  AST_BIT_WITH_SAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> samp_tick_o); // R7
  AST_BIT_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> (scnt_q == SC_W'(OVS - 1))); // R7
  AST_SHIFT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> !samp_tick_o); // R8
  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!samp_tick_o && !bit_tick_o && div_act_i == '0)); // R9
endmodule

bind uart_baud_clk uart_baud_chk #(.DIV_W(DIV_W), .OVS(OVS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .src_sel_i   (src_sel_i),
  .tmr_ovf_i   (tmr_ovf_i),
  .div_hi_we_i (div_hi_we_i),
  .div_act_i   (div_act),
  .samp_tick_o (samp_tick_o),
  .bit_tick_o  (bit_tick_o)
);

// File: tb/uart_baud_clk_bench.sv
module uart_baud_clk_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  localparam int TMO = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_lo = '0, div_hi = '0;
  logic       div_lo_we = 1'b0, div_hi_we = 1'b0;
  logic       src_sel = 1'b0, dbl = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       tmr_ovf = 1'b0, cpu_en = 1'b0;
  logic       samp_tick, bit_tick;

  int cyc = 0;
  int ovf_per = 0, cpu_per = 1;
  int ovf_cnt = 0, cpu_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_baud_clk u_uart_baud_clk (
    .clk_i(clk), .rst_ni(rst_n),
    .div_lo_i(div_lo), .div_lo_we_i(div_lo_we),
    .div_hi_i(div_hi), .div_hi_we_i(div_hi_we),
    .src_sel_i(src_sel), .dbl_i(dbl), .mode_i(mode),
    .tmr_ovf_i(tmr_ovf), .cpu_en_i(cpu_en),
    .samp_tick_o(samp_tick), .bit_tick_o(bit_tick)
  );

  // pulse generators for timer overflow and CPU enable
  always @(negedge clk) begin
    if (ovf_per > 0) begin
      ovf_cnt = ovf_cnt + 1;
      if (ovf_cnt >= ovf_per) begin tmr_ovf = 1'b1; ovf_cnt = 0; end
      else tmr_ovf = 1'b0;
    end else tmr_ovf = 1'b0;
    if (cpu_per > 0) begin
      cpu_cnt = cpu_cnt + 1;
      if (cpu_cnt >= cpu_per) begin cpu_en = 1'b1; cpu_cnt = 0; end
      else cpu_en = 1'b0;
    end else cpu_en = 1'b0;
  end

  // mode(2) src(1) dbl(1) div(16) ovf_per(8) cpu_per(8) samp_per(16) bit_per(16)
  localparam logic [67:0] VEC [NVEC] = '{
    {2'b01, 1'b1, 1'b0, 16'd3, 8'd0, 8'd1, 16'd3,  16'd48},   // R2
    {2'b11, 1'b1, 1'b1, 16'd7, 8'd0, 8'd1, 16'd7,  16'd112},  // R2 dbl ignored
    {2'b01, 1'b0, 1'b1, 16'd4, 8'd5, 8'd1, 16'd5,  16'd80},   // R4 R5
    {2'b01, 1'b0, 1'b0, 16'd0, 8'd5, 8'd1, 16'd10, 16'd160},  // R5 halved
    {2'b11, 1'b0, 1'b0, 16'd2, 8'd3, 8'd1, 16'd6,  16'd96},   // R4 R5
    {2'b10, 1'b0, 1'b1, 16'd0, 8'd0, 8'd1, 16'd1,  16'd16},   // R6 CPU/16
    {2'b10, 1'b1, 1'b0, 16'd9, 8'd4, 8'd1, 16'd2,  16'd32},   // R6 CPU/32, others ignored
    {2'b10, 1'b0, 1'b1, 16'd0, 8'd0, 8'd3, 16'd3,  16'd48},   // R6
    {2'b10, 1'b0, 1'b0, 16'd0, 8'd0, 8'd2, 16'd4,  16'd64}    // R6
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_lo(input logic [7:0] v);
    @(negedge clk); div_lo = v; div_lo_we = 1'b1;
    @(negedge clk); div_lo_we = 1'b0;
  endtask

  task automatic wr_hi(input logic [7:0] v);
    @(negedge clk); div_hi = v; div_hi_we = 1'b1;
    @(negedge clk); div_hi_we = 1'b0;
  endtask

  task automatic wait_tick(input bit use_bit, output bit ok);
    int g = 0;
    while (!(use_bit ? bit_tick : samp_tick) && g < TMO) begin @(negedge clk); g++; end
    ok = (g < TMO);
  endtask

  task automatic meas(input bit use_bit, output int per);
    bit ok;
    int t0;
    per = -1;
    wait_tick(use_bit, ok);
    if (!ok) return;
    @(negedge clk);
    wait_tick(use_bit, ok);
    if (!ok) return;
    t0 = cyc;
    @(negedge clk);
    wait_tick(use_bit, ok);
    if (ok) per = cyc - t0;
  endtask

  task automatic count_ticks(input int n, output int s, output int b);
    s = 0; b = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (samp_tick) s++;
      if (bit_tick) b++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s, b, p;
    // R9: reset
    repeat (3) @(negedge clk);
    check(samp_tick == 1'b0 && bit_tick == 1'b0, "R9", {samp_tick, bit_tick}, 0);
    rst_n = 1'b1;
    mode = 2'b01; src_sel = 1'b1;
    count_ticks(100, s, b);
    check(s == 0, "R9 divisor zero after reset", s, 0);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      logic [67:0] v;
      v = VEC[k];
      mode = v[67:66]; src_sel = v[65]; dbl = v[64];
      ovf_per = int'(v[47:40]); cpu_per = int'(v[39:32]);
      wr_lo(v[55:48]); wr_hi(v[63:56]);
      meas(1'b0, p);
      check(p == int'(v[31:16]), $sformatf("R2/R4/R5/R6 vec%0d sample period", k), p, int'(v[31:16]));
      meas(1'b1, p);
      check(p == int'(v[15:0]), $sformatf("R7 vec%0d bit period", k), p, int'(v[15:0]));
    end

    // R3: zero divisor
    mode = 2'b01; src_sel = 1'b1; ovf_per = 2; cpu_per = 1;
    wr_lo(8'h00); wr_hi(8'h00);
    count_ticks(300, s, b);
    check(s == 0 && b == 0, "R3", s + b, 0);

    // R4: timer selected, divisor running, no overflow
    ovf_per = 0; wr_lo(8'd2); wr_hi(8'd0); src_sel = 1'b0;
    count_ticks(5, s, b);
    count_ticks(200, s, b);
    check(s == 0, "R4 divisor ignored", s, 0);

    // R8: shift mode
    src_sel = 1'b1; mode = 2'b00;
    count_ticks(5, s, b);
    count_ticks(200, s, b);
    check(s == 0 && b == 0, "R8", s + b, 0);

    // R1: torn write protection
    mode = 2'b01; src_sel = 1'b1;
    wr_lo(8'h10); wr_hi(8'h00);
    meas(1'b0, p);
    check(p == 16, "R1 committed 0x0010", p, 16);
    wr_lo(8'h05);
    meas(1'b0, p);
    check(p == 16, "R1 low staged only", p, 16);
    wr_hi(8'h00);
    meas(1'b0, p);
    check(p == 5, "R1 commit on high write", p, 5);
    // R1: both in one cycle -> new low used
    @(negedge clk); div_lo = 8'h06; div_hi = 8'h00; div_lo_we = 1'b1; div_hi_we = 1'b1;
    @(negedge clk); div_lo_we = 1'b0; div_hi_we = 1'b0;
    meas(1'b0, p);
    check(p == 6, "R1 simultaneous write", p, 6);
    // R1: high byte path, 0x0102 = 258
    wr_lo(8'h02); wr_hi(8'h01);
    meas(1'b0, p);
    check(p == 258, "R1 high byte weight", p, 258);

    // R7: coincidence at divisor 1
    wr_lo(8'h01); wr_hi(8'h00);
    begin
      int lone = 0, between = 0, bad_gap = 0, nbit = 0;
      bit ok;
      wait_tick(1'b1, ok);
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (bit_tick && !samp_tick) lone++;
        if (samp_tick) between++;
        if (bit_tick) begin
          nbit++;
          if (between != 16) bad_gap++;
          between = 0;
        end
      end
      check(lone == 0, "R7 bit without sample", lone, 0);
      check(bad_gap == 0 && nbit >= 10, "R7 sixteen per bit", bad_gap, 0);
      check(nbit == 12, "R7 bit count at divisor 1", nbit, 12);
    end

    // R9: reset mid-run clears outputs and divisor
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(samp_tick == 1'b0 && bit_tick == 1'b0, "R9 async reset", {samp_tick, bit_tick}, 0);
    rst_n = 1'b1;
    count_ticks(100, s, b);
    check(s == 0, "R9 divisor cleared", s, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule